// File: doc/BRIEF.md
# Windowed Register Pointer Controller

This block holds the processor status word and the current-window pointer for a register file that is built from overlapping windows. Each clock cycle it takes at most one request: step into a new window (save), step back (restore), return from a trap, or overwrite the status word. The pointer moves around a ring of `NWIN` windows. Every move is checked against a per-window invalid mask before it is allowed.

When a move or a write is refused, the block puts out a one-cycle trap pulse with a code that tells the trap logic what went wrong. The whole state is also presented as one packed 32-bit read word that software-visible logic can return. The storage for the register windows, the trap vector dispatch and the interrupt controller are not part of this block.

Top module: `wndptr_ctrl`

## Requirements
- R1: Reset, active low on `rst_n`, sets the pointer to 0 and sets the supervisor bit. It clears trap-enable, condition codes, FP-enable, previous-supervisor and the interrupt level. `trap_valid` is low. With the default version 0xA5, `stat_word` reads 0xA5000080.
- R2: `req_op` = 1 (save) moves the pointer to the current value minus one. From 0 it wraps to `NWIN`-1.
- R3: `req_op` = 2 (restore) moves the pointer to the current value plus one. From `NWIN`-1 it wraps to 0.
- R4: If a save finds `win_invalid` set at its candidate pointer, it raises trap code 1 (overflow) and leaves all state unchanged.
- R5: If a restore finds `win_invalid` set at its candidate pointer, it raises trap code 2 (underflow) and leaves all state unchanged.
- R6: `req_op` = 3 (return from trap) while trap-enable is already 1 raises trap code 3 (illegal) and leaves all state unchanged.
- R7: A return from trap with trap-enable at 0 behaves like a restore for the pointer, including the mask check. On an invalid candidate it raises code 2 and changes nothing. Otherwise it sets trap-enable and copies previous-supervisor into supervisor.
- R8: `req_op` = 4 (status write) loads fields from `req_data`:
  - condition codes from bits 23:20
  - FP-enable from bit 12
  - interrupt level from bits 11:8
  - supervisor from bit 7
  - previous-supervisor from bit 6
  - trap-enable from bit 5
  - pointer from bits 4:0

  All other data bits are ignored.
- R9: A status write whose bits 4:0 are `NWIN` or greater raises trap code 3 and updates no field.
- R10: `stat_word` is packed as follows:
  - version in bits 31:24
  - condition codes in bits 23:20
  - zeros in bits 19:13
  - FP-enable in bit 12
  - interrupt level in bits 11:8
  - supervisor in bit 7
  - previous-supervisor in bit 6
  - trap-enable in bit 5
  - pointer in bits 4:0

  `win_ptr` equals bits 4:0.
- R11: Requests are sampled on the rising clock edge. State and trap outputs change at that same edge. `trap_valid` is high for exactly the one cycle after a refused request. Op codes 0 and 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_op | input | 3 | Request code: 0 none, 1 save, 2 restore, 3 return from trap, 4 status write |
| req_data | input | 32 | Operand for the status write |
| win_invalid | input | NWIN | One bit per window; a set bit forbids entering that window |
| stat_word | output | 32 | Packed status read value |
| win_ptr | output | 5 | Current window pointer |
| trap_valid | output | 1 | One-cycle trap pulse |
| trap_code | output | 2 | Trap kind: 1 overflow, 2 underflow, 3 illegal |

## Verification
On every cycle, the bound checker confirms the following:
- the pointer stays inside the ring
- an accepted save or restore lands on the wrapped neighbour of the previous pointer
- a trap pulse follows a real request and leaves the status word untouched
- an idle cycle changes nothing

Field loading from a status write, the packing of each field into the read word, and the supervisor copy on return from trap depend on the data patterns involved. Only the bench's vector table and directed cases show those behaviours.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

   localparam int PTR_W  = 5;
   localparam int WORD_W = 32;

   localparam int POS_ICC = 20;
   localparam int POS_EF  = 12;
   localparam int POS_PIL = 8;
   localparam int POS_S   = 7;
   localparam int POS_PS  = 6;
   localparam int POS_ET  = 5;
   localparam int POS_VER = 24;

   typedef enum logic [2:0] {
      OP_IDLE    = 3'd0,
      OP_SAVE    = 3'd1,
      OP_RESTORE = 3'd2,
      OP_RETT    = 3'd3,
      OP_WRSTAT  = 3'd4
   } op_e;

   typedef enum logic [1:0] {
      TC_NONE = 2'd0,
      TC_OVF  = 2'd1,
      TC_UNF  = 2'd2,
      TC_ILL  = 2'd3
   } trap_e;

   typedef struct packed {
      logic [3:0]       icc;
      logic             ef;
      logic [3:0]       pil;
      logic             sup;
      logic             psup;
      logic             tren;
      logic [PTR_W-1:0] ptr;
   } stat_t;

   function automatic stat_t unpack_word(input logic [WORD_W-1:0] w);
      stat_t s;
      s.icc  = w[POS_ICC +: 4];
      s.ef   = w[POS_EF];
      s.pil  = w[POS_PIL +: 4];
      s.sup  = w[POS_S];
      s.psup = w[POS_PS];
      s.tren = w[POS_ET];
      s.ptr  = w[PTR_W-1:0];
      return s;
   endfunction

endpackage

// File: rtl/wpc_ring_step.sv
module wpc_ring_step #(
   parameter int NWIN  = 8,
   parameter int PTR_W = 5
) (
   input  logic [PTR_W-1:0] cur,
   output logic [PTR_W-1:0] dec,
   output logic [PTR_W-1:0] inc
);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(NWIN - 1);
   localparam bit               POW2 = ((NWIN & (NWIN - 1)) == 0);

   generate
      if (POW2) begin : g_pow2
         always_comb begin
            dec = (cur - 1'b1) & LAST;
            inc = (cur + 1'b1) & LAST;
         end
      end else begin : g_gen
         always_comb begin
            dec = (cur == '0)   ? LAST : cur - 1'b1;
            inc = (cur == LAST) ? '0   : cur + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/wpc_mask_probe.sv
module wpc_mask_probe #(
   parameter int NWIN  = 8,
   parameter int PTR_W = 5
) (
   input  logic [NWIN-1:0]  mask,
   input  logic [PTR_W-1:0] idx,
   output logic             hit
);
   logic [NWIN-1:0] sel;

   generate
      for (genvar i = 0; i < NWIN; i++) begin : g_dec
         assign sel[i] = (idx == PTR_W'(i));
      end
   endgenerate

   assign hit = |(sel & mask);
endmodule

// File: rtl/wpc_stat_pack.sv
module wpc_stat_pack
   import wpc_pkg::*;
#(
   parameter logic [7:0] VERSION = 8'hA5
) (
   input  stat_t             st,
   output logic [WORD_W-1:0] word
);
   always_comb begin
      word                   = '0;
      word[POS_VER +: 8]     = VERSION;
      word[POS_ICC +: 4]     = st.icc;
      word[POS_EF]           = st.ef;
      word[POS_PIL +: 4]     = st.pil;
      word[POS_S]            = st.sup;
      word[POS_PS]           = st.psup;
      word[POS_ET]           = st.tren;
      word[PTR_W-1:0]        = st.ptr;
   end
endmodule

// File: rtl/wndptr_ctrl.sv
module wndptr_ctrl
   import wpc_pkg::*;
#(
   parameter int         NWIN    = 8,
   parameter logic [7:0] VERSION = 8'hA5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        req_op,
   input  logic [31:0]       req_data,
   input  logic [NWIN-1:0]   win_invalid,
   output logic [31:0]       stat_word,
   output logic [4:0]        win_ptr,
   output logic              trap_valid,
   output logic [1:0]        trap_code
);
   localparam logic [PTR_W:0] NWIN_L = (PTR_W+1)'(NWIN);

   initial begin
      if (NWIN < 2 || NWIN > (1 << PTR_W))
         $error("wndptr_ctrl: NWIN must be within 2..32");
   end

   stat_t            st_q, st_d;
   logic             tv_d;
   trap_e            tc_d, tc_q;
   logic [PTR_W-1:0] ptr_dec, ptr_inc;
   logic             hit_dec, hit_inc;
   logic             wr_bad;

   wpc_ring_step #(.NWIN(NWIN), .PTR_W(PTR_W)) u_step (
      .cur (st_q.ptr),
      .dec (ptr_dec),
      .inc (ptr_inc)
   );

   wpc_mask_probe #(.NWIN(NWIN), .PTR_W(PTR_W)) u_probe_dec (
      .mask (win_invalid),
      .idx  (ptr_dec),
      .hit  (hit_dec)
   );

   wpc_mask_probe #(.NWIN(NWIN), .PTR_W(PTR_W)) u_probe_inc (
      .mask (win_invalid),
      .idx  (ptr_inc),
      .hit  (hit_inc)
   );

   assign wr_bad = ({1'b0, req_data[PTR_W-1:0]} >= NWIN_L);

   always_comb begin
      st_d = st_q;
      tv_d = 1'b0;
      tc_d = TC_NONE;
      case (req_op)
         OP_SAVE: begin
            if (hit_dec) begin
               tv_d = 1'b1;
               tc_d = TC_OVF;
            end else begin
               st_d.ptr = ptr_dec;
            end
         end
         OP_RESTORE: begin
            if (hit_inc) begin
               tv_d = 1'b1;
               tc_d = TC_UNF;
            end else begin
               st_d.ptr = ptr_inc;
            end
         end
         OP_RETT: begin
            if (st_q.tren) begin
               tv_d = 1'b1;
               tc_d = TC_ILL;
            end else if (hit_inc) begin
               tv_d = 1'b1;
               tc_d = TC_UNF;
            end else begin
               st_d.ptr  = ptr_inc;
               st_d.tren = 1'b1;
               st_d.sup  = st_q.psup;
            end
         end
         OP_WRSTAT: begin
            if (wr_bad) begin
               tv_d = 1'b1;
               tc_d = TC_ILL;
            end else begin
               st_d = unpack_word(req_data);
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= '0;
         st_q.sup   <= 1'b1;
         trap_valid <= 1'b0;
         tc_q       <= TC_NONE;
      end else begin
         st_q       <= st_d;
         trap_valid <= tv_d;
         tc_q       <= tc_d;
      end
   end

   wpc_stat_pack #(.VERSION(VERSION)) u_pack (
      .st   (st_q),
      .word (stat_word)
   );

   assign win_ptr   = st_q.ptr;
   assign trap_code = tc_q;
endmodule

// File: rtl/wpc_checker.sv
module wpc_checker #(
   parameter int NWIN = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic [2:0]      req_op,
   input logic [31:0]     stat_word,
   input logic [4:0]      win_ptr,
   input logic            trap_valid
);
   localparam logic [4:0] LAST = 5'(NWIN - 1);

   AST_PTR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
      win_ptr <= LAST); // R2

   AST_SAVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(req_op) == 3'd1 && !trap_valid) |->
      win_ptr == (($past(win_ptr) == 5'd0) ? LAST : $past(win_ptr) - 5'd1)); // R2

   AST_RESTORE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(req_op) == 3'd2 && !trap_valid) |->
      win_ptr == (($past(win_ptr) == LAST) ? 5'd0 : $past(win_ptr) + 5'd1)); // R3

   AST_TRAP_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |-> $past(req_op) != 3'd0); // R11

   AST_TRAP_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |-> $stable(stat_word)); // R4

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(req_op) == 3'd0) |-> ($stable(stat_word) && !trap_valid)); // R11
endmodule

bind wndptr_ctrl wpc_checker #(.NWIN(NWIN)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_op     (req_op),
   .stat_word  (stat_word),
   .win_ptr    (win_ptr),
   .trap_valid (trap_valid)
);

// File: tb/wndptr_ctrl_test.sv
module wndptr_ctrl_test;
   localparam int NWIN = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [2:0]      req_op = 3'd0;
   logic [31:0]     req_data = '0;
   logic [NWIN-1:0] win_invalid = '0;
   logic [31:0]     stat_word;
   logic [4:0]      win_ptr;
   logic            trap_valid;
   logic [1:0]      trap_code;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   wndptr_ctrl #(.NWIN(NWIN), .VERSION(8'hA5)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_op      (req_op),
      .req_data    (req_data),
      .win_invalid (win_invalid),
      .stat_word   (stat_word),
      .win_ptr     (win_ptr),
      .trap_valid  (trap_valid),
      .trap_code   (trap_code)
   );

   // row: op(3) data(32) mask(8) trap(1) code(2) stat(32)
   localparam int NV = 17;
   localparam logic [77:0] TBL [0:NV-1] = '{
      {3'd1, 32'h0,        8'h00, 1'b0, 2'd0, 32'hA5000087}, // R2 wrap 0->7
      {3'd1, 32'h0,        8'h00, 1'b0, 2'd0, 32'hA5000086}, // R2
      {3'd2, 32'h0,        8'h00, 1'b0, 2'd0, 32'hA5000087}, // R3
      {3'd2, 32'h0,        8'h00, 1'b0, 2'd0, 32'hA5000080}, // R3 wrap 7->0
      {3'd1, 32'h0,        8'h80, 1'b1, 2'd1, 32'hA5000080}, // R4
      {3'd2, 32'h0,        8'h02, 1'b1, 2'd2, 32'hA5000080}, // R5
      {3'd4, 32'hFFCFF943, 8'h00, 1'b0, 2'd0, 32'hA5C01943}, // R8 R10
      {3'd4, 32'h00000028, 8'h00, 1'b1, 2'd3, 32'hA5C01943}, // R9
      {3'd4, 32'h0000001F, 8'h00, 1'b1, 2'd3, 32'hA5C01943}, // R9
      {3'd3, 32'h0,        8'h00, 1'b0, 2'd0, 32'hA5C019E4}, // R7
      {3'd3, 32'h0,        8'h00, 1'b1, 2'd3, 32'hA5C019E4}, // R6
      {3'd0, 32'hFFFFFFFF, 8'hFF, 1'b0, 2'd0, 32'hA5C019E4}, // R11
      {3'd4, 32'h00000007, 8'h00, 1'b0, 2'd0, 32'hA5000007}, // R8
      {3'd3, 32'h0,        8'h01, 1'b1, 2'd2, 32'hA5000007}, // R7 masked
      {3'd3, 32'h0,        8'h00, 1'b0, 2'd0, 32'hA5000020}, // R7 wrap, S<-PS=0
      {3'd1, 32'h0,        8'h80, 1'b1, 2'd1, 32'hA5000020}, // R4 at 0
      {3'd1, 32'h0,        8'h7F, 1'b0, 2'd0, 32'hA5000027}  // R2
   };

   function automatic string tag_of(input logic [2:0] op, input logic [1:0] code);
      case (op)
         3'd1:    return (code != 0) ? "R4" : "R2";
         3'd2:    return (code != 0) ? "R5" : "R3";
         3'd3:    return (code == 3) ? "R6" : "R7";
         3'd4:    return (code != 0) ? "R9" : "R8";
         default: return "R11";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog R11 actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 stat", stat_word, 32'hA5000080);
      chk("R1 trap", {31'b0, trap_valid}, 32'h0);
      chk("R1 ptr",  {27'b0, win_ptr}, 32'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         req_op      = TBL[i][77:75];
         req_data    = TBL[i][74:43];
         win_invalid = TBL[i][42:35];
         @(negedge clk);
         chk({tag_of(TBL[i][77:75], TBL[i][33:32]), " trap"},
             {29'b0, trap_valid, trap_code}, {29'b0, TBL[i][34:32]});
         chk({tag_of(TBL[i][77:75], TBL[i][33:32]), " R10 stat"},
             stat_word, TBL[i][31:0]);
         chk("R10 ptr", {27'b0, win_ptr}, {27'b0, TBL[i][4:0]});
      end

      // R11: trap pulse lasts one cycle
      req_op = 3'd1; win_invalid = '1;
      @(negedge clk);
      chk("R4 trap", {29'b0, trap_valid, trap_code}, 32'h5);
      req_op = 3'd0; win_invalid = '0;
      @(negedge clk);
      chk("R11 pulse end", {31'b0, trap_valid}, 32'h0);
      chk("R11 stat", stat_word, 32'hA5000027);

      // R11: unused op code is ignored
      req_op = 3'd5; req_data = 32'h00000003;
      @(negedge clk);
      chk("R11 op5 stat", stat_word, 32'hA5000027);
      chk("R11 op5 trap", {31'b0, trap_valid}, 32'h0);
      req_op = 3'd0;

      // R1: reset mid-run
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 stat again", stat_word, 32'hA5000080);
      chk("R1 ptr again", {27'b0, win_ptr}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      summary();
      $finish;
   end
endmodule